// File: doc/BRIEF.md
# Two-Wire Serial Register-Access Slave Port

This block lets an external master read and write a 64-entry, 8-bit register file over a two-wire serial link made of a clock line and a bidirectional data line. Both lines are oversampled by a faster system clock through two-flop synchronizers. Edges are detected on the synchronized levels. The data line is driven only as an open-drain pull-down: the port either pulls it low or releases it.

A transfer opens with a START condition. The master then sends a device address byte, then a register address byte, and after that data bytes. The device address byte holds a fixed five-bit identity, then two bits taken from one address-select strap pin (the inverted pin, then the true pin), then a direction bit. The register address byte gives a six-bit register number and a mode flag. With the flag set, the register number steps after every data byte, so a burst reads or writes consecutive registers. With the flag clear, every data byte must be preceded by a fresh register address byte. The port acknowledges each byte it accepts. When reading, it stops driving data once the master does not acknowledge a byte.

FSM states: `ST_IDLE` (no transfer), `ST_DEV` (shifting the device address byte), `ST_DEV_ACK` (acknowledge slot for it), `ST_RAB` (shifting the register address byte), `ST_RAB_ACK`, `ST_WR_DATA` (shifting a byte to be written), `ST_WR_ACK`, `ST_RD_DATA` (driving a register byte out), `ST_RD_ACK` (sampling the master's acknowledge), and `ST_IGNORE` (released until the next START or STOP). The transitions are as follows:
- START from any state goes to `ST_DEV`, and STOP from any state goes to `ST_IDLE`.
- On the eighth bit, `ST_DEV` goes to `ST_DEV_ACK` on a match and to `ST_IGNORE` otherwise.
- `ST_DEV_ACK` goes to `ST_RAB`, and `ST_RAB` goes to `ST_RAB_ACK`.
- `ST_RAB_ACK` goes to `ST_RD_DATA` or `ST_WR_DATA`, according to the direction bit.
- `ST_WR_DATA` goes to `ST_WR_ACK`. `ST_WR_ACK` then goes to `ST_WR_DATA` in auto-increment mode and to `ST_RAB` in alternating mode.
- `ST_RD_DATA` goes to `ST_RD_ACK`. `ST_RD_ACK` then goes to `ST_RD_DATA` on an acknowledge in auto-increment mode, to `ST_RAB` on an acknowledge in alternating mode, and to `ST_IGNORE` on a not-acknowledge.

Top module: `sreg_slave_port`

## Requirements
- R1: After reset the data line is released (`sd_drive_low` = 0) and every register reads back as 0x00.
- R2: A falling data line while the clock is high starts a transfer from any state; a rising data line while the clock is high ends it and releases the data line. A repeated START in mid-transfer begins a new device address byte.
- R3: The device address byte is sent MSB first as 1,0,0,0,1, NOT addr_sel, addr_sel, then the direction bit (0 = write, 1 = read). On a match, the port pulls the data line low through the ninth clock.
- R4: A device address byte that does not match is not acknowledged. The data line stays released for the rest of the transfer and no register changes.
- R5: In the register address byte, bits 5:0 select the register and bit 7 is ignored.
- R6: With direction 0, each data byte is stored in the selected register and acknowledged in the ninth clock.
- R7: With direction 1, the port drives the selected register MSB first, and its drive on the data line changes only while the clock is low.
- R8: Bit 6 = 1 in the register address byte selects auto-increment mode. The register number advances by one after each data byte in either direction and wraps from 63 to 0.
- R9: Bit 6 = 0 selects alternating mode, where the byte after each data byte is again a register address byte.
- R10: During a read, a not-acknowledge from the master (data line high in the ninth clock) ends data output. The line stays released until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sc_in | input | 1 | Serial clock line as seen at the pad |
| sd_in | input | 1 | Serial data line as seen at the pad (wired-AND of all drivers) |
| addr_sel | input | 1 | Address-select strap that sets the two low device address bits |
| sd_drive_low | output | 1 | Open-drain enable: 1 pulls the data line low, 0 releases it |

## Verification
The bench writes bursts that cross register 63. A port that fails to wrap would land the last byte in the wrong register, and the auto-increment read-back would show a stale value. It also mixes alternating transfers with reads and writes. A port that kept incrementing in that mode would take a register address byte as data and corrupt a register. Other stimuli test the address-select strap with both polarities, a wrong address with bit 7 set in the register byte, a not-acknowledge followed by extra clocks, and a repeated START in mid-write. A port that drove the line after a not-acknowledge, answered a foreign address, or ignored a repeated START would return bytes other than 0xFF or acknowledge where it must not.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_RAB,
        ST_RAB_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } port_state_e;
endpackage

// File: rtl/sreg_line_sync.sv
module sreg_line_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
            prev  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], raw};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sreg_proto_fsm.sv
module sreg_proto_fsm
    import sreg_pkg::*;
#(
    parameter int          AW       = 6,
    parameter int          DW       = 8,
    parameter int          AUTO_BIT = 6,
    parameter int          ID_W     = DW - 3,
    parameter logic [ID_W-1:0] DEV_ID = 5'b10001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sc_lvl,
    input  logic          sc_rise,
    input  logic          sc_fall,
    input  logic          sd_lvl,
    input  logic          sd_rise,
    input  logic          sd_fall,
    input  logic          addr_sel,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          drive_low,
    output port_state_e   state_o
);
    localparam int CNT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

    port_state_e      state, nxt;
    logic [DW-1:0]    shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic             phase;
    logic             rw_q;
    logic             auto_q;
    logic             mack_q;
    logic             ack_low;
    logic             tx_on;
    logic [AW-1:0]    reg_addr;

    logic             start_ev, stop_ev, last_bit, dev_hit;
    logic [DW-1:0]    byte_in;
    logic [AW-1:0]    next_addr;

    assign start_ev  = sd_fall & sc_lvl;
    assign stop_ev   = sd_rise & sc_lvl;
    assign byte_in   = {shreg[DW-2:0], sd_lvl};
    assign last_bit  = (bit_cnt == LAST);
    assign dev_hit   = (byte_in[DW-1:1] == {DEV_ID, ~addr_sel, addr_sel});
    assign next_addr = reg_addr + 1'b1;
    assign rd_addr   = (state == ST_RD_ACK) ? next_addr : reg_addr;
    assign drive_low = ack_low | (tx_on & ~shreg[DW-1]);
    assign state_o   = state;

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_ev) begin
            nxt = ST_DEV;
        end else if (stop_ev) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = ST_IDLE;
                ST_DEV:     if (sc_rise && last_bit) nxt = dev_hit ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK: if (sc_fall && phase) nxt = ST_RAB;
                ST_RAB:     if (sc_rise && last_bit) nxt = ST_RAB_ACK;
                ST_RAB_ACK: if (sc_fall && phase) nxt = rw_q ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA: if (sc_rise && last_bit) nxt = ST_WR_ACK;
                ST_WR_ACK:  if (sc_fall && phase) nxt = auto_q ? ST_WR_DATA : ST_RAB;
                ST_RD_DATA: if (sc_rise && last_bit) nxt = ST_RD_ACK;
                ST_RD_ACK:  if (sc_fall && phase)
                                nxt = !mack_q ? ST_IGNORE : (auto_q ? ST_RD_DATA : ST_RAB);
                ST_IGNORE:  nxt = ST_IGNORE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and line drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            phase    <= 1'b0;
            rw_q     <= 1'b0;
            auto_q   <= 1'b0;
            mack_q   <= 1'b0;
            ack_low  <= 1'b0;
            tx_on    <= 1'b0;
            reg_addr <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev || stop_ev) begin
                bit_cnt <= '0;
                phase   <= 1'b0;
                ack_low <= 1'b0;
                tx_on   <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_RAB, ST_WR_DATA: begin
                        if (sc_rise) begin
                            shreg   <= byte_in;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (last_bit) begin
                                if (state == ST_DEV) rw_q <= sd_lvl;
                                if (state == ST_RAB) begin
                                    reg_addr <= byte_in[AW-1:0];
                                    auto_q   <= byte_in[AUTO_BIT];
                                end
                                if (state == ST_WR_DATA) begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= reg_addr;
                                    wr_data <= byte_in;
                                end
                            end
                        end
                    end
                    ST_DEV_ACK, ST_RAB_ACK, ST_WR_ACK: begin
                        if (sc_fall) begin
                            if (!phase) begin
                                phase   <= 1'b1;
                                ack_low <= 1'b1;
                            end else begin
                                phase   <= 1'b0;
                                bit_cnt <= '0;
                                ack_low <= 1'b0;
                                if (state == ST_RAB_ACK && rw_q) begin
                                    shreg <= rd_data;
                                    tx_on <= 1'b1;
                                end
                                if (state == ST_WR_ACK && auto_q) reg_addr <= next_addr;
                            end
                        end
                    end
                    ST_RD_DATA: begin
                        if (sc_rise) bit_cnt <= bit_cnt + 1'b1;
                        if (sc_fall) shreg <= {shreg[DW-2:0], 1'b0};
                    end
                    ST_RD_ACK: begin
                        if (sc_rise) begin
                            mack_q <= ~sd_lvl;
                            phase  <= 1'b1;
                        end
                        if (sc_fall) begin
                            if (!phase) begin
                                tx_on <= 1'b0;
                            end else begin
                                phase   <= 1'b0;
                                bit_cnt <= '0;
                                if (mack_q && auto_q) begin
                                    reg_addr <= next_addr;
                                    shreg    <= rd_data;
                                    tx_on    <= 1'b1;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sreg_slave_port.sv
module sreg_slave_port
    import sreg_pkg::*;
#(
    parameter int AW          = 6,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int AUTO_BIT    = 6,
    parameter int ID_W        = DW - 3,
    parameter logic [ID_W-1:0] DEV_ID = 5'b10001
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sc_in,
    input  logic sd_in,
    input  logic addr_sel,
    output logic sd_drive_low
);
    logic          sc_lvl, sc_rise, sc_fall;
    logic          sd_lvl, sd_rise, sd_fall;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;
    logic          wr_en;
    port_state_e   port_state;

    sreg_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sc_sync (
        .clk(clk), .rst_n(rst_n), .raw(sc_in),
        .level(sc_lvl), .rise(sc_rise), .fall(sc_fall)
    );

    sreg_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sd_sync (
        .clk(clk), .rst_n(rst_n), .raw(sd_in),
        .level(sd_lvl), .rise(sd_rise), .fall(sd_fall)
    );

    sreg_proto_fsm #(
        .AW(AW), .DW(DW), .AUTO_BIT(AUTO_BIT), .ID_W(ID_W), .DEV_ID(DEV_ID)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sc_lvl(sc_lvl), .sc_rise(sc_rise), .sc_fall(sc_fall),
        .sd_lvl(sd_lvl), .sd_rise(sd_rise), .sd_fall(sd_fall),
        .addr_sel(addr_sel),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .drive_low(sd_drive_low), .state_o(port_state)
    );

    sreg_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/sreg_port_checker.sv
module sreg_port_checker
    import sreg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        sc_lvl,
    input logic        sd_rise,
    input logic        sd_fall,
    input port_state_e state,
    input logic        drive,
    input logic        we
);
    // R7: line drive moves only while the synchronized clock is low
    a_r7_drive_moves_sc_low: assert property (@(posedge clk) disable iff (!rst_n)
        (drive != $past(drive)) |-> !sc_lvl);

    // R2: START leads into the device-address state
    a_r2_start_to_dev: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_fall && sc_lvl) |=> (state == ST_DEV));

    // R2: STOP returns to idle
    a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_rise && sc_lvl) |=> (state == ST_IDLE));

    // R4 / R10: no drive while idle or ignoring
    a_r4_quiet_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_IGNORE) |-> !drive);

    // R6: a register write follows only a completed write-data byte
    a_r6_write_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ($past(state) == ST_WR_DATA));

    // R10: the ignore state is left only by START or STOP
    a_r10_ignore_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE && !(sc_lvl && (sd_rise || sd_fall))) |=> (state == ST_IGNORE));
endmodule

bind sreg_slave_port sreg_port_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sc_lvl(sc_lvl),
    .sd_rise(sd_rise), .sd_fall(sd_fall),
    .state(port_state), .drive(sd_drive_low), .we(wr_en)
);

// File: tb/tb_sreg_slave_port.sv
module tb_sreg_slave_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_sc = 1'b1;
    logic m_sd = 1'b1;
    logic as_pin = 1'b1;
    logic sd_low;
    logic sd_bus;

    assign sd_bus = m_sd & ~sd_low;
    always #2 clk = ~clk;   // 250 MHz

    sreg_slave_port dut (
        .clk(clk), .rst_n(rst_n), .sc_in(m_sc), .sd_in(sd_bus),
        .addr_sel(as_pin), .sd_drive_low(sd_low)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] model [64];
    logic [7:0] buf_q [8];

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dev_byte(input bit rw);
        return {5'b10001, ~as_pin, as_pin, rw};
    endfunction

    function automatic logic [7:0] rab_byte(input bit top7, input bit auto_f, input logic [5:0] a);
        return {top7, auto_f, a};
    endfunction

    task automatic bus_start();
        m_sd = 1'b1; hold(6);
        m_sc = 1'b1; hold(8);
        m_sd = 1'b0; hold(8);
        m_sc = 1'b0; hold(6);
    endtask

    task automatic bus_stop();
        m_sd = 1'b0; hold(6);
        m_sc = 1'b1; hold(8);
        m_sd = 1'b1; hold(8);
    endtask

    task automatic clock_bit(input bit b, output bit seen);
        m_sd = b;    hold(6);
        m_sc = 1'b1; hold(4);
        seen = sd_bus; hold(4);
        m_sc = 1'b0; hold(6);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(~give_ack, s);
    endtask

    // R6 / R8: burst write from buf_q
    task automatic write_burst(input logic [5:0] a, input int n, input bit top7);
        bit ack;
        logic [5:0] idx;
        bus_start();
        send_byte(dev_byte(1'b0), ack); chk("R3 device ack (write)", ack, 1);
        send_byte(rab_byte(top7, 1'b1, a), ack); chk("R8 reg byte ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(buf_q[i], ack); chk("R6 data ack", ack, 1);
            idx = a + 6'(i);
            model[idx] = buf_q[i];
        end
        bus_stop();
    endtask

    // R7 / R8: burst read, NAK on last byte
    task automatic read_burst(input logic [5:0] a, input int n, input bit top7, input string tag);
        bit ack;
        logic [7:0] b;
        logic [5:0] idx;
        bus_start();
        send_byte(dev_byte(1'b1), ack); chk("R3 device ack (read)", ack, 1);
        send_byte(rab_byte(top7, 1'b1, a), ack); chk("R5 reg byte ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            idx = a + 6'(i);
            chk(tag, b, model[idx]);
        end
        bus_stop();
        chk("R2 released after stop", sd_low, 0);
    endtask

    // R9: alternating write of two registers
    task automatic write_alt(input logic [5:0] a0, input logic [7:0] d0,
                             input logic [5:0] a1, input logic [7:0] d1);
        bit ack;
        bus_start();
        send_byte(dev_byte(1'b0), ack); chk("R3 device ack", ack, 1);
        send_byte(rab_byte(1'b0, 1'b0, a0), ack); chk("R9 first reg byte ack", ack, 1);
        send_byte(d0, ack); chk("R9 first data ack", ack, 1);
        send_byte(rab_byte(1'b0, 1'b0, a1), ack); chk("R9 second reg byte ack", ack, 1);
        send_byte(d1, ack); chk("R9 second data ack", ack, 1);
        bus_stop();
        model[a0] = d0;
        model[a1] = d1;
    endtask

    // R9: alternating read of two registers
    task automatic read_alt(input logic [5:0] a0, input logic [5:0] a1);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(dev_byte(1'b1), ack); chk("R3 device ack", ack, 1);
        send_byte(rab_byte(1'b0, 1'b0, a0), ack); chk("R9 reg byte ack", ack, 1);
        recv_byte(b, 1'b1); chk("R9 alternating read first", b, model[a0]);
        send_byte(rab_byte(1'b0, 1'b0, a1), ack); chk("R9 reg byte ack after data", ack, 1);
        recv_byte(b, 1'b0); chk("R9 alternating read second", b, model[a1]);
        bus_stop();
    endtask

    initial begin
        bit ack;
        logic [7:0] b;
        logic [31:0] seed;
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        seed = $urandom(32'h5EED_2024);
        hold(5);
        rst_n = 1'b1;
        hold(20);

        // R1: reset state
        chk("R1 line released after reset", sd_low, 0);
        read_burst(6'd0, 4, 1'b0, "R1 register zero after reset");

        // R8: wrap 62 -> 63 -> 0
        buf_q[0] = 8'h11; buf_q[1] = 8'h22; buf_q[2] = 8'h33;
        write_burst(6'd62, 3, 1'b0);
        read_burst(6'd63, 2, 1'b0, "R8 auto read across wrap");
        read_burst(6'd62, 1, 1'b0, "R8 reg 62 after wrap write");

        // R9: alternating mode
        write_alt(6'd5, 8'hA5, 6'd9, 8'h5A);
        read_alt(6'd9, 6'd5);
        read_burst(6'd6, 1, 1'b0, "R9 neighbour untouched");

        // R5: bit 7 of register byte ignored
        buf_q[0] = 8'hC3; buf_q[1] = 8'h3C;
        write_burst(6'd20, 2, 1'b1);
        read_burst(6'd20, 2, 1'b0, "R5 top bit ignored");

        // R4: foreign device address, with bit 7 set in the register byte
        bus_start();
        send_byte(8'h8C, ack); chk("R4 no ack for swapped strap bits", ack, 0);
        send_byte(rab_byte(1'b1, 1'b1, 6'd30), ack); chk("R4 no ack on register byte", ack, 0);
        send_byte(8'hEE, ack); chk("R4 no ack on data", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'h0A, ack); chk("R4 no ack for wrong prefix", ack, 0);
        bus_stop();
        read_burst(6'd30, 1, 1'b0, "R4 register unchanged");

        // R3: other strap polarity
        as_pin = 1'b0;
        hold(4);
        buf_q[0] = 8'h77;
        write_burst(6'd40, 1, 1'b0);
        read_burst(6'd40, 1, 1'b0, "R3 strap low access");
        bus_start();
        send_byte(8'h8A, ack); chk("R3 old strap code rejected", ack, 0);
        bus_stop();
        as_pin = 1'b1;
        hold(4);

        // R10: NAK ends output
        bus_start();
        send_byte(dev_byte(1'b1), ack); chk("R3 device ack", ack, 1);
        send_byte(rab_byte(1'b0, 1'b1, 6'd5), ack); chk("R8 reg byte ack", ack, 1);
        recv_byte(b, 1'b0); chk("R10 byte before nak", b, model[5]);
        recv_byte(b, 1'b0); chk("R10 released after nak", b, 8'hFF);
        bus_stop();

        // R2: repeated START mid-write switches to read
        bus_start();
        send_byte(dev_byte(1'b0), ack); chk("R3 device ack", ack, 1);
        send_byte(rab_byte(1'b0, 1'b1, 6'd50), ack); chk("R8 reg byte ack", ack, 1);
        bus_start();
        send_byte(dev_byte(1'b1), ack); chk("R2 device ack after repeated start", ack, 1);
        send_byte(rab_byte(1'b0, 1'b1, 6'd62), ack); chk("R2 reg byte ack", ack, 1);
        recv_byte(b, 1'b0); chk("R2 read after repeated start", b, model[62]);
        bus_stop();
        read_burst(6'd50, 1, 1'b0, "R2 no write from aborted burst");

        // Random mix: R6, R7, R8, R9
        for (int it = 0; it < 10; it++) begin
            logic [5:0] a;
            logic [5:0] a2;
            int n;
            a = 6'($urandom % 64);
            n = 1 + int'($urandom % 4);
            if ($urandom % 3 == 0) begin
                a2 = 6'($urandom % 64);
                write_alt(a, 8'($urandom), a2, 8'($urandom));
                read_alt(a2, a);
            end else begin
                for (int k = 0; k < n; k++) buf_q[k] = 8'($urandom);
                write_burst(a, n, 1'($urandom));
                read_burst(a, n, 1'($urandom), "R7 random burst read back");
            end
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule